// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating A/D converter. Software picks one of five analog inputs, a measurement mode and one of four full-scale counts, then pulses a start request. The sequencer drives the external analog switches through three timed phases. First it closes the auto-zero switch. Next it connects the chosen input to the integrator for exactly N count clocks. Last it applies a reference of the polarity that opposes the integrated charge, and it counts until the comparator reports a zero crossing.

The sign of the input is taken from the comparator at the end of the integrate phase. The sign, the de-integrate count and an overrange flag are stored in a result register that changes only when a conversion finishes. A one-cycle interrupt pulse marks completion. Conversion time scales with N, since the auto-zero and integrate phases each last N count clocks and de-integration is capped at 2N. A stop request abandons a conversion at once.

Top module: `dsadc_seq`

## Requirements
- R1: After reset `busy`, `irq`, every switch output and every result output are 0.
- R2: `res_sel` sets the full-scale count N: 0 gives 6400, 1 gives 3200, 2 gives 1600 and 3 gives 800. `sw_az` stays high for exactly N count clocks, and the integrate phase (`sw_pos` nonzero) follows for exactly N count clocks.
- R3: During integration `sw_pos` has only bit `chan_sel` set. A start request with `chan_sel` above 4 is ignored and `busy` stays 0.
- R4: `mode` encodes 0 as voltage, 1 as differential, 2 as resistance, and 3 acts as voltage. In differential mode `sw_neg` has bit ((`chan_sel`+1) mod 5) set during integration. In every other mode `sw_neg` stays 0.
- R5: `cmp_in` is sampled on the last integrate clock. A value of 1 means positive, so de-integration uses `sw_ref_neg` and `res_neg`=0. A value of 0 means negative, so de-integration uses `sw_ref_pos` and `res_neg`=1.
- R6: `res_mag` equals the number of de-integrate clocks that pass before `cmp_in` first differs from the sampled polarity, and `res_ovr`=0.
- R7: If no crossing occurs within 2N de-integrate clocks, the conversion ends with `res_mag`=2N and `res_ovr`=1.
- R8: In resistance mode a positive sampled polarity skips de-integration. The conversion ends straight after integration with `res_mag`=0, `res_neg`=0 and `res_ovr`=1.
- R9: `irq` is a single-cycle pulse. New result values appear in the same cycle as the pulse, and the result outputs hold their value at every other time.
- R10: A start request while `busy` is high is ignored. The running conversion keeps its settings and its timing.
- R11: `stop` during a conversion returns the block to idle on the next cycle. All switches open, no `irq` is raised and the result is left unchanged.
- R12: At most one of `sw_az`, the input switches and the two reference switches is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, one cycle |
| stop | input | 1 | Abort request |
| chan_sel | input | 3 | Input channel, 0 to 4 |
| mode | input | 2 | Measurement mode |
| res_sel | input | 2 | Full-scale count select |
| cmp_in | input | 1 | Comparator, 1 = integrator above zero |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_pos | output | 5 | Positive-leg input switch enables |
| sw_neg | output | 5 | Negative-leg input switch enables |
| sw_ref_pos | output | 1 | Positive reference switch enable |
| sw_ref_neg | output | 1 | Negative reference switch enable |
| busy | output | 1 | Conversion in progress |
| res_mag | output | 14 | Result magnitude in counts |
| res_neg | output | 1 | Result sign, 1 = negative |
| res_ovr | output | 1 | Overrange or rejected polarity |
| irq | output | 1 | Completion pulse |

## Verification
A phase counter that ends on the wrong value shows up as an auto-zero or integrate window of the wrong length. The bench measures these windows on the switch outputs during the same conversion. A wrong latched polarity or configuration shows up as the wrong reference switch at the first de-integrate cycle, or as the wrong input switch, well before any result exists. Errors in counting or in the overrange limit show up only in the result popped at the interrupt pulse, at the end of each conversion. Stray interrupts and result changes outside a pulse are caught in the cycle they happen.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_AZ    = 3'd1,
    ST_INT   = 3'd2,
    ST_DEINT = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  localparam logic [1:0] MD_VOLT = 2'd0;
  localparam logic [1:0] MD_DIFF = 2'd1;
  localparam logic [1:0] MD_RES  = 2'd2;

  // full-scale count: the smallest count doubled once per step below select 3
  function automatic int fs_count(input logic [1:0] sel, input int base);
    return base << (3 - int'(sel));
  endfunction

  // companion channel for the negative leg, wrapping at the channel count
  function automatic int next_chan(input int ch, input int nch);
    return (ch + 1 >= nch) ? 0 : ch + 1;
  endfunction

endpackage

// File: rtl/dsadc_tick_gen.sv
module dsadc_tick_gen #(
  parameter int PRESCALE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pc;

  assign tick = run && (pc == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (!run)   pc <= '0;
    else if (tick)   pc <= '0;
    else             pc <= pc + PW'(1);
  end
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int MAG_W   = 14,
  parameter int FS_BASE = 800,
  parameter int NUM_CH  = 5,
  parameter int CH_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       mode,
  input  logic [1:0]       res_sel,
  input  logic             cmp_in,
  input  logic             tick,
  output seq_state_t       state,
  output logic [CH_W-1:0]  chan_q,
  output logic [1:0]       mode_q,
  output logic             pol_q,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_neg,
  output logic             res_ovr,
  output logic             start_ok,
  output logic             phase_end,
  output logic             cross_det
);
  logic [1:0]       res_q;
  logic [MAG_W-1:0] cnt;
  logic [MAG_W-1:0] fs_cnt;
  logic [MAG_W-1:0] lim_cnt;
  logic             reject;

  assign fs_cnt    = MAG_W'(fs_count(res_q, FS_BASE));
  assign lim_cnt   = MAG_W'(2 * fs_count(res_q, FS_BASE));
  assign start_ok  = start && (state == ST_IDLE) && (int'(chan_sel) < NUM_CH);
  assign phase_end = tick && (cnt == fs_cnt - MAG_W'(1));
  assign cross_det = tick && (state == ST_DEINT) && (cmp_in != pol_q);
  assign reject    = (mode_q == MD_RES) && cmp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      chan_q  <= '0;
      mode_q  <= '0;
      res_q   <= '0;
      pol_q   <= 1'b0;
      res_mag <= '0;
      res_neg <= 1'b0;
      res_ovr <= 1'b0;
    end else if (stop && state != ST_IDLE) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state  <= ST_AZ;
            cnt    <= '0;
            chan_q <= chan_sel;
            mode_q <= mode;
            res_q  <= res_sel;
          end
        end
        ST_AZ: begin
          if (phase_end) begin
            state <= ST_INT;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + MAG_W'(1);
          end
        end
        ST_INT: begin
          if (phase_end) begin
            pol_q <= cmp_in;
            cnt   <= '0;
            if (reject) begin
              state   <= ST_DONE;
              res_mag <= '0;
              res_neg <= 1'b0;
              res_ovr <= 1'b1;
            end else begin
              state <= ST_DEINT;
            end
          end else if (tick) begin
            cnt <= cnt + MAG_W'(1);
          end
        end
        ST_DEINT: begin
          if (cross_det) begin
            state   <= ST_DONE;
            res_mag <= cnt;
            res_neg <= ~pol_q;
            res_ovr <= 1'b0;
          end else if (tick && cnt == lim_cnt - MAG_W'(1)) begin
            state   <= ST_DONE;
            res_mag <= lim_cnt;
            res_neg <= ~pol_q;
            res_ovr <= 1'b1;
          end else if (tick) begin
            cnt <= cnt + MAG_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsadc_sw_decode.sv
module dsadc_sw_decode
  import dsadc_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3
) (
  input  seq_state_t        state,
  input  logic [CH_W-1:0]   chan_q,
  input  logic [1:0]        mode_q,
  input  logic              pol_q,
  output logic              sw_az,
  output logic [NUM_CH-1:0] sw_pos,
  output logic [NUM_CH-1:0] sw_neg,
  output logic              sw_ref_pos,
  output logic              sw_ref_neg
);
  logic in_int;
  logic in_deint;
  logic diff;
  int   partner;

  assign in_int     = (state == ST_INT);
  assign in_deint   = (state == ST_DEINT);
  assign diff       = (mode_q == MD_DIFF);
  assign partner    = next_chan(int'(chan_q), NUM_CH);
  assign sw_az      = (state == ST_AZ);
  assign sw_ref_pos = in_deint && !pol_q;
  assign sw_ref_neg = in_deint && pol_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign sw_pos[i] = in_int && (chan_q == CH_W'(i));
    assign sw_neg[i] = in_int && diff && (partner == i);
  end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int MAG_W    = 14,
  parameter int FS_BASE  = 800,
  parameter int NUM_CH   = 5,
  parameter int CH_W     = 3,
  parameter int PRESCALE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [1:0]        mode,
  input  logic [1:0]        res_sel,
  input  logic              cmp_in,
  output logic              sw_az,
  output logic [NUM_CH-1:0] sw_pos,
  output logic [NUM_CH-1:0] sw_neg,
  output logic              sw_ref_pos,
  output logic              sw_ref_neg,
  output logic              busy,
  output logic [MAG_W-1:0]  res_mag,
  output logic              res_neg,
  output logic              res_ovr,
  output logic              irq
);
  seq_state_t      state;
  logic [CH_W-1:0] chan_q;
  logic [1:0]      mode_q;
  logic            pol_q;
  logic            tick;
  logic            start_ok;
  logic            phase_end;
  logic            cross_det;

  assign busy = (state != ST_IDLE);
  assign irq  = (state == ST_DONE);

  dsadc_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  dsadc_fsm #(
    .MAG_W(MAG_W), .FS_BASE(FS_BASE), .NUM_CH(NUM_CH), .CH_W(CH_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .chan_sel(chan_sel), .mode(mode), .res_sel(res_sel), .cmp_in(cmp_in),
    .tick(tick), .state(state), .chan_q(chan_q), .mode_q(mode_q),
    .pol_q(pol_q), .res_mag(res_mag), .res_neg(res_neg), .res_ovr(res_ovr),
    .start_ok(start_ok), .phase_end(phase_end), .cross_det(cross_det)
  );

  dsadc_sw_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sw (
    .state(state), .chan_q(chan_q), .mode_q(mode_q), .pol_q(pol_q),
    .sw_az(sw_az), .sw_pos(sw_pos), .sw_neg(sw_neg),
    .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg)
  );
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int MAG_W  = 14,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              sw_az,
  input logic [NUM_CH-1:0] sw_pos,
  input logic [NUM_CH-1:0] sw_neg,
  input logic              sw_ref_pos,
  input logic              sw_ref_neg,
  input logic              busy,
  input logic [MAG_W-1:0]  res_mag,
  input logic              res_neg,
  input logic              res_ovr,
  input logic              irq,
  input logic              start_ok,
  input logic              cross_det
);
  p_one_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_az, |sw_pos, sw_ref_pos, sw_ref_neg}));

  p_onehot_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_pos));

  p_neg_with_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_neg) |-> ($countones(sw_neg) == 1 && |sw_pos && sw_neg != sw_pos));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable({res_mag, res_neg, res_ovr}));

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && busy) |=> (!busy && !irq));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !irq && !stop) |=> busy);

  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> !busy);

  p_cross_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_det && !stop) |=> (irq && !res_ovr));
endmodule

bind dsadc_seq dsadc_seq_chk #(.MAG_W(MAG_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .sw_az(sw_az), .sw_pos(sw_pos),
  .sw_neg(sw_neg), .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg),
  .busy(busy), .res_mag(res_mag), .res_neg(res_neg), .res_ovr(res_ovr),
  .irq(irq), .start_ok(start_ok), .cross_det(cross_det)
);

// File: tb/dsadc_seq_bench.sv
`timescale 1ns/1ps
module dsadc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [2:0]  chan_sel = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  res_sel = '0;
  logic        cmp_in = 1'b0;
  logic        sw_az;
  logic [4:0]  sw_pos;
  logic [4:0]  sw_neg;
  logic        sw_ref_pos;
  logic        sw_ref_neg;
  logic        busy;
  logic [13:0] res_mag;
  logic        res_neg;
  logic        res_ovr;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] expq[$];
  logic [15:0] last_res = '0;

  always #2 clk = ~clk;

  dsadc_seq u_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .chan_sel(chan_sel), .mode(mode), .res_sel(res_sel), .cmp_in(cmp_in),
    .sw_az(sw_az), .sw_pos(sw_pos), .sw_neg(sw_neg),
    .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg), .busy(busy),
    .res_mag(res_mag), .res_neg(res_neg), .res_ovr(res_ovr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int full_scale(input logic [1:0] r);
    case (r)
      2'd0: return 6400;
      2'd1: return 3200;
      2'd2: return 1600;
      default: return 800;
    endcase
  endfunction

  // monitor: every completion pulse must match the oldest expected result
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected irq", 1, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(res_mag == e[13:0], "R6/R7 magnitude", int'(res_mag), int'(e[13:0]));
        check(res_neg == e[14], "R5 sign", int'(res_neg), int'(e[14]));
        check(res_ovr == e[15], "R7/R8 overrange", int'(res_ovr), int'(e[15]));
        last_res = e;
      end
    end
  end

  task automatic run_conv(input logic [1:0] r, input logic [2:0] ch, input logic [1:0] md,
                          input bit pos, input int k, input int poke);
    int n;
    int fs;
    bit rej;
    logic [4:0] exp_neg;
    fs  = full_scale(r);
    rej = (md == 2'd2) && pos;
    if (rej)        expq.push_back({1'b1, 1'b0, 14'd0});
    else if (k >= 2 * fs) expq.push_back({1'b1, ~pos, 14'(2 * fs)});
    else            expq.push_back({1'b0, ~pos, 14'(k)});
    exp_neg = (md == 2'd1) ? (5'd1 << ((int'(ch) + 1) % 5)) : 5'd0;

    @(negedge clk);
    res_sel = r; chan_sel = ch; mode = md; cmp_in = pos; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    n = 0;
    while (sw_az) begin
      n++;
      if (poke > 0 && n == poke) begin start = 1'b1; res_sel = ~r; end
      else begin start = 1'b0; res_sel = r; end
      @(negedge clk);
    end
    start = 1'b0; res_sel = r;
    check(n == fs, "R2 auto-zero length", n, fs);
    check(sw_pos == (5'd1 << ch), "R3 input switch", int'(sw_pos), int'(5'd1 << ch));
    check(sw_neg == exp_neg, "R4 negative leg", int'(sw_neg), int'(exp_neg));
    n = 0;
    while (|sw_pos) begin
      n++;
      @(negedge clk);
    end
    check(n == fs, "R2 integrate length", n, fs);
    if (rej) begin
      check(!sw_ref_pos && !sw_ref_neg, "R8 no de-integrate", int'({sw_ref_pos, sw_ref_neg}), 0);
    end else begin
      check(sw_ref_neg == pos && sw_ref_pos == !pos, "R5 reference polarity",
            int'({sw_ref_pos, sw_ref_neg}), pos ? 1 : 2);
      if (k < 2 * fs) begin
        repeat (k) @(negedge clk);
        cmp_in = !pos;
      end
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !irq, "R1 idle after reset", int'({busy, irq}), 0);
    check({sw_az, sw_pos, sw_neg, sw_ref_pos, sw_ref_neg} == '0, "R1 switches open",
          int'({sw_az, sw_pos, sw_neg, sw_ref_pos, sw_ref_neg}), 0);
    check({res_ovr, res_neg, res_mag} == '0, "R1 result cleared",
          int'({res_ovr, res_neg, res_mag}), 0);

    run_conv(2'd3, 3'd0, 2'd0, 1'b1, 300, 0);   // R6 positive voltage
    run_conv(2'd3, 3'd4, 2'd0, 1'b0, 123, 0);   // R5 negative voltage
    run_conv(2'd2, 3'd2, 2'd1, 1'b1, 0, 0);     // R4 differential, immediate crossing
    run_conv(2'd3, 3'd4, 2'd1, 1'b0, 50, 0);    // R4 partner wraps to channel 0
    run_conv(2'd3, 3'd1, 2'd2, 1'b0, 700, 0);   // R8 resistance, valid polarity
    run_conv(2'd3, 3'd1, 2'd2, 1'b1, 10, 0);    // R8 resistance, rejected polarity
    run_conv(2'd3, 3'd3, 2'd0, 1'b1, 1599, 0);  // R7 last count before limit
    run_conv(2'd3, 3'd3, 2'd0, 1'b0, 5000, 0);  // R7 overrange
    run_conv(2'd0, 3'd2, 2'd3, 1'b1, 7, 0);     // R2 6400 counts, R4 mode 3 as voltage
    run_conv(2'd1, 3'd0, 2'd0, 1'b1, 10, 100);  // R10 restart attempt during auto-zero

    // R3 channel out of range is ignored
    @(negedge clk);
    chan_sel = 3'd5; mode = 2'd0; res_sel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && sw_az == 1'b0, "R3 bad channel ignored", int'(busy), 0);

    // R11 stop during integration
    @(negedge clk);
    chan_sel = 3'd1; cmp_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sw_az) @(negedge clk);
    repeat (10) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(!busy, "R11 idle after stop", int'(busy), 0);
    check({sw_az, sw_pos, sw_neg, sw_ref_pos, sw_ref_neg} == '0, "R11 switches open",
          int'({sw_az, sw_pos, sw_neg, sw_ref_pos, sw_ref_neg}), 0);
    check({res_ovr, res_neg, res_mag} == last_res, "R11 result kept",
          int'({res_ovr, res_neg, res_mag}), int'(last_res));
    repeat (5) @(negedge clk);
    check(!irq && expq.size() == 0, "R9 no pending or stray result", int'(expq.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule